// File: doc/BRIEF.md
# Context Stack Sequencer

This block saves and restores processor context on a byte-wide stack in memory that grows toward lower addresses. It runs one command at a time and spreads each one over a fixed number of cycles. An interrupt entry stores five context bytes, sets the interrupt mask in the condition codes and fetches a two-byte vector. An interrupt return reloads the same five bytes in reverse. A subroutine call saves a two-byte return address and jumps to a target. A subroutine return reloads that address. The block also pushes or pulls a single byte, and it can reset the low byte of the stack pointer. It owns the 16-bit stack pointer. It drives the memory address, write data and read/write strobes, and it reports results to the register file through write strobes.

Commands enter through a valid/ready handshake. `cmd_ready` is high only while the block is idle. A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. Until that edge the requester must hold `cmd_valid`, the opcode and the operands steady. Every operand is sampled at acceptance, so later changes have no effect on a running sequence. Memory reads are combinational: `mem_rdata` must reflect `mem_addr` in the same cycle that `mem_re` is high. Register-file results appear as one-cycle strobes.

Top module: `stk_seq`

## Requirements
- R1: After reset the stack pointer is 0x00FF. `busy` and every memory and register strobe are low, and `cmd_ready` is high.
- R2: Opcode 0 (interrupt entry) writes PC low, PC high, X, A and CCR, in that order, at SP, SP-1, SP-2, SP-3 and SP-4. It leaves SP lower by exactly 5, never stores the high index byte, and keeps `busy` high for 9 cycles.
- R3: After stacking, interrupt entry reads `vec_addr` and then `vec_addr+1`. In its last cycle it writes PC with those bytes (high, low) and writes CCR as the sampled CCR with bit 3 (interrupt mask) set.
- R4: Opcode 1 (interrupt return) reads SP+1 up to SP+5 as CCR, A, X, PC high and PC low. It restores all four registers in its last cycle, taking every CCR bit from the stacked byte, and keeps `busy` high for 7 cycles.
- R5: Opcode 2 (call) writes PC low at SP and PC high at SP-1, then writes PC with `call_target`, over 4 busy cycles.
- R6: Opcode 3 (return) reads PC high at SP+1 and PC low at SP+2, then writes PC with them, over 4 busy cycles.
- R7: Opcode 4 writes `push_byte` at SP and then decrements SP. Opcode 5 increments SP, reads the new SP and presents the byte on `pull_byte` with `pull_valid`. Each takes 2 busy cycles and neither writes CCR.
- R8: Opcode 6 sets SP[7:0] to 0xFF, keeps SP[15:8], and takes 1 busy cycle.
- R9: `cmd_ready` is low while `busy` is high. Operand changes after acceptance do not alter the sequence.
- R10: Opcode 7 takes 1 busy cycle with no memory access, no register write and no change to SP. A write and a read are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 3 | Command opcode (0..7, see requirements) |
| ctx_pc | input | 16 | Program counter to stack |
| ctx_a | input | 8 | Accumulator to stack |
| ctx_x | input | 8 | Index low byte to stack |
| ctx_ccr | input | 8 | Condition codes to stack |
| call_target | input | 16 | Jump address for a call |
| vec_addr | input | 16 | Address of the vector high byte |
| push_byte | input | 8 | Byte for a single push |
| busy | output | 1 | Sequence in progress |
| sp_out | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data (combinational) |
| pc_wr | output | 1 | PC write strobe |
| pc_wdata | output | 16 | PC write value |
| a_wr | output | 1 | A write strobe |
| a_wdata | output | 8 | A write value |
| x_wr | output | 1 | X write strobe |
| x_wdata | output | 8 | X write value |
| ccr_wr | output | 1 | CCR write strobe |
| ccr_wdata | output | 8 | CCR write value |
| pull_valid | output | 1 | Single pulled byte valid |
| pull_byte | output | 8 | Single pulled byte |

## Verification
Two events can fall in the same cycle: the last cycle of one sequence, with its final memory transfer, and the arrival of the next command. The bench raises `cmd_valid` for a pull during the final cycle of a push. It checks that `cmd_ready` is low in that cycle and that the pull is accepted only on the following edge. It then checks that the pull reads back the byte just pushed, at an address based on the stack pointer the push left behind.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int STEP_W = 4;

  typedef enum logic [2:0] {
    OP_IRQ  = 3'd0,
    OP_RTI  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_PUSH = 3'd4,
    OP_PULL = 3'd5,
    OP_RSP  = 3'd6,
    OP_NOP  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    XK_IDLE = 2'd0,
    XK_WR   = 2'd1,
    XK_RD   = 2'd2,
    XK_VEC  = 2'd3
  } xk_e;

  typedef enum logic [2:0] {
    F_PCL  = 3'd0,
    F_PCH  = 3'd1,
    F_X    = 3'd2,
    F_A    = 3'd3,
    F_CCR  = 3'd4,
    F_BYTE = 3'd5
  } fld_e;

  typedef struct packed {
    xk_e  kind;
    fld_e fld;
    logic vec_lo;
    logic wr_pc;
    logic wr_ax;
    logic wr_ccr;
    logic set_i;
    logic emit;
    logic rsp;
    logic last;
  } step_t;

  // Micro-step table: step 0 is a lead cycle, memory transfers follow,
  // and a tail cycle carries the register-file writes.
  function automatic step_t decode_step(input op_e op, input logic [STEP_W-1:0] s);
    step_t t;
    t = '0;
    case (op)
      OP_IRQ: begin
        case (s)
          4'd0: ;
          4'd1: begin t.kind = XK_WR;  t.fld = F_PCL; end
          4'd2: begin t.kind = XK_WR;  t.fld = F_PCH; end
          4'd3: begin t.kind = XK_WR;  t.fld = F_X;   end
          4'd4: begin t.kind = XK_WR;  t.fld = F_A;   end
          4'd5: begin t.kind = XK_WR;  t.fld = F_CCR; end
          4'd6: begin t.kind = XK_VEC; t.fld = F_PCH; end
          4'd7: begin t.kind = XK_VEC; t.fld = F_PCL; t.vec_lo = 1'b1; end
          4'd8: begin t.wr_pc = 1'b1; t.wr_ccr = 1'b1; t.set_i = 1'b1; t.last = 1'b1; end
          default: t.last = 1'b1;
        endcase
      end
      OP_RTI: begin
        case (s)
          4'd0: ;
          4'd1: begin t.kind = XK_RD; t.fld = F_CCR; end
          4'd2: begin t.kind = XK_RD; t.fld = F_A;   end
          4'd3: begin t.kind = XK_RD; t.fld = F_X;   end
          4'd4: begin t.kind = XK_RD; t.fld = F_PCH; end
          4'd5: begin t.kind = XK_RD; t.fld = F_PCL; end
          4'd6: begin t.wr_pc = 1'b1; t.wr_ax = 1'b1; t.wr_ccr = 1'b1; t.last = 1'b1; end
          default: t.last = 1'b1;
        endcase
      end
      OP_CALL: begin
        case (s)
          4'd0: ;
          4'd1: begin t.kind = XK_WR; t.fld = F_PCL; end
          4'd2: begin t.kind = XK_WR; t.fld = F_PCH; end
          4'd3: begin t.wr_pc = 1'b1; t.last = 1'b1; end
          default: t.last = 1'b1;
        endcase
      end
      OP_RET: begin
        case (s)
          4'd0: ;
          4'd1: begin t.kind = XK_RD; t.fld = F_PCH; end
          4'd2: begin t.kind = XK_RD; t.fld = F_PCL; end
          4'd3: begin t.wr_pc = 1'b1; t.last = 1'b1; end
          default: t.last = 1'b1;
        endcase
      end
      OP_PUSH: begin
        case (s)
          4'd0: ;
          4'd1: begin t.kind = XK_WR; t.fld = F_BYTE; t.last = 1'b1; end
          default: t.last = 1'b1;
        endcase
      end
      OP_PULL: begin
        case (s)
          4'd0: ;
          4'd1: begin t.kind = XK_RD; t.fld = F_BYTE; t.emit = 1'b1; t.last = 1'b1; end
          default: t.last = 1'b1;
        endcase
      end
      OP_RSP: begin
        t.rsp  = 1'b1;
        t.last = 1'b1;
      end
      default: t.last = 1'b1;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/stk_step_dec.sv
module stk_step_dec
  import stk_pkg::*;
(
  input  logic              active,
  input  op_e               op,
  input  logic [STEP_W-1:0] step,
  output step_t             st
);

  always_comb begin
    if (active) st = decode_step(op, step);
    else        st = '0;
  end

endmodule

// File: rtl/stk_sp_unit.sv
module stk_sp_unit #(
  parameter int          AW       = 16,
  parameter logic [15:0] SP_RESET = 16'h00FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec,
  input  logic          inc,
  input  logic          rsp,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_next_up
);

  localparam int LOW_W = 8;

  assign sp_next_up = sp + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)   sp <= AW'(SP_RESET);
    else if (rsp) sp <= {sp[AW-1:LOW_W], {LOW_W{1'b1}}};
    else if (dec) sp <= sp - 1'b1;
    else if (inc) sp <= sp_next_up;
  end

  // R8
  rsp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp |=> (sp[LOW_W-1:0] == {LOW_W{1'b1}}) && (sp[AW-1:LOW_W] == $past(sp[AW-1:LOW_W])));

  // R10
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec || inc || rsp) |=> $stable(sp));

endmodule

// File: rtl/stk_frame.sv
module stk_frame
  import stk_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] in_pc,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_x,
  input  logic [DW-1:0] in_ccr,
  input  logic [AW-1:0] in_tgt,
  input  logic [AW-1:0] in_vec,
  input  logic [DW-1:0] in_byte,
  input  logic          cap,
  input  fld_e          fld,
  input  logic [DW-1:0] cap_data,
  output logic [DW-1:0] push_data,
  output logic [AW-1:0] pc_val,
  output logic [AW-1:0] tgt_val,
  output logic [AW-1:0] vec_val,
  output logic [DW-1:0] a_val,
  output logic [DW-1:0] x_val,
  output logic [DW-1:0] ccr_val
);

  logic [DW-1:0] r_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_val  <= '0;
      tgt_val <= '0;
      vec_val <= '0;
      a_val   <= '0;
      x_val   <= '0;
      ccr_val <= '0;
      r_byte  <= '0;
    end else if (load) begin
      pc_val  <= in_pc;
      tgt_val <= in_tgt;
      vec_val <= in_vec;
      a_val   <= in_a;
      x_val   <= in_x;
      ccr_val <= in_ccr;
      r_byte  <= in_byte;
    end else if (cap) begin
      case (fld)
        F_PCL:   pc_val[DW-1:0]  <= cap_data;
        F_PCH:   pc_val[AW-1:DW] <= cap_data;
        F_X:     x_val           <= cap_data;
        F_A:     a_val           <= cap_data;
        F_CCR:   ccr_val         <= cap_data;
        default: r_byte          <= cap_data;
      endcase
    end
  end

  always_comb begin
    case (fld)
      F_PCL:   push_data = pc_val[DW-1:0];
      F_PCH:   push_data = pc_val[AW-1:DW];
      F_X:     push_data = x_val;
      F_A:     push_data = a_val;
      F_CCR:   push_data = ccr_val;
      default: push_data = r_byte;
    endcase
  end

  // R9
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load || cap) |=> $stable(pc_val) && $stable(a_val) && $stable(x_val) && $stable(ccr_val)
                       && $stable(tgt_val) && $stable(vec_val));

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter logic [15:0] SP_RESET  = 16'h00FF,
  parameter int          IMASK_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] ctx_pc,
  input  logic [DW-1:0] ctx_a,
  input  logic [DW-1:0] ctx_x,
  input  logic [DW-1:0] ctx_ccr,
  input  logic [AW-1:0] call_target,
  input  logic [AW-1:0] vec_addr,
  input  logic [DW-1:0] push_byte,
  output logic          busy,
  output logic [AW-1:0] sp_out,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          pc_wr,
  output logic [AW-1:0] pc_wdata,
  output logic          a_wr,
  output logic [DW-1:0] a_wdata,
  output logic          x_wr,
  output logic [DW-1:0] x_wdata,
  output logic          ccr_wr,
  output logic [DW-1:0] ccr_wdata,
  output logic          pull_valid,
  output logic [DW-1:0] pull_byte
);

  localparam logic [DW-1:0] IMASK = DW'(1) << IMASK_BIT;

  logic              busy_q;
  op_e               op_q;
  logic [STEP_W-1:0] step_q;
  step_t             st;
  logic              accept;
  logic [AW-1:0]     sp;
  logic [AW-1:0]     sp_up;
  logic [DW-1:0]     push_data;
  logic [AW-1:0]     pc_val, tgt_val, vec_val;
  logic [DW-1:0]     ccr_val;
  logic              is_wr, is_rd, is_vec;

  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && !busy_q;
  assign busy      = busy_q;
  assign sp_out    = sp;

  // Sequence control: opcode and step index held while busy.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_NOP;
      step_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      op_q   <= op_e'(cmd_op);
      step_q <= '0;
    end else if (busy_q) begin
      if (st.last) busy_q <= 1'b0;
      else         step_q <= step_q + 1'b1;
    end
  end

  stk_step_dec u_dec (
    .active (busy_q),
    .op     (op_q),
    .step   (step_q),
    .st     (st)
  );

  assign is_wr  = (st.kind == XK_WR);
  assign is_rd  = (st.kind == XK_RD);
  assign is_vec = (st.kind == XK_VEC);

  stk_sp_unit #(.AW(AW), .SP_RESET(SP_RESET)) u_sp (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec        (is_wr),
    .inc        (is_rd),
    .rsp        (st.rsp),
    .sp         (sp),
    .sp_next_up (sp_up)
  );

  stk_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .in_pc     (ctx_pc),
    .in_a      (ctx_a),
    .in_x      (ctx_x),
    .in_ccr    (ctx_ccr),
    .in_tgt    (call_target),
    .in_vec    (vec_addr),
    .in_byte   (push_byte),
    .cap       (is_rd || is_vec),
    .fld       (st.fld),
    .cap_data  (mem_rdata),
    .push_data (push_data),
    .pc_val    (pc_val),
    .tgt_val   (tgt_val),
    .vec_val   (vec_val),
    .a_val     (a_wdata),
    .x_val     (x_wdata),
    .ccr_val   (ccr_val)
  );

  // Memory side: push at SP, pull at SP+1, vector at base or base+1.
  always_comb begin
    mem_addr = '0;
    if (is_wr)       mem_addr = sp;
    else if (is_rd)  mem_addr = sp_up;
    else if (is_vec) mem_addr = vec_val + AW'(st.vec_lo);
  end

  assign mem_we    = is_wr;
  assign mem_re    = is_rd || is_vec;
  assign mem_wdata = is_wr ? push_data : '0;

  // Register-file side.
  assign pc_wr      = st.wr_pc;
  assign pc_wdata   = (op_q == OP_CALL) ? tgt_val : pc_val;
  assign a_wr       = st.wr_ax;
  assign x_wr       = st.wr_ax;
  assign ccr_wr     = st.wr_ccr;
  assign ccr_wdata  = st.set_i ? (ccr_val | IMASK) : ccr_val;
  assign pull_valid = st.emit;
  assign pull_byte  = st.emit ? mem_rdata : '0;

  // R10
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_we || mem_re || pc_wr || a_wr || x_wr || ccr_wr || pull_valid));

  // R7
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp_out == AW'($past(mem_addr) - 1'b1));

  // R7
  pull_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && is_rd) |-> mem_addr == AW'(sp_out + 1'b1));

  // R7
  pull_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && is_rd) |=> sp_out == $past(mem_addr));

  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  // R9
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> !busy);

  // R3
  imask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr_wr && op_q == OP_IRQ) |-> ccr_wdata[IMASK_BIT]);

endmodule

// File: tb/tb_stk_seq.sv
module tb_stk_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [2:0]  cmd_op;
  logic [15:0] ctx_pc;
  logic [7:0]  ctx_a, ctx_x, ctx_ccr;
  logic [15:0] call_target, vec_addr;
  logic [7:0]  push_byte;
  logic        busy;
  logic [15:0] sp_out, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, mem_re;
  logic        pc_wr, a_wr, x_wr, ccr_wr, pull_valid;
  logic [15:0] pc_wdata;
  logic [7:0]  a_wdata, x_wdata, ccr_wdata, pull_byte;

  always #10 clk = ~clk;

  stk_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .ctx_pc(ctx_pc), .ctx_a(ctx_a), .ctx_x(ctx_x), .ctx_ccr(ctx_ccr),
    .call_target(call_target), .vec_addr(vec_addr), .push_byte(push_byte),
    .busy(busy), .sp_out(sp_out), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .pc_wr(pc_wr), .pc_wdata(pc_wdata), .a_wr(a_wr), .a_wdata(a_wdata),
    .x_wr(x_wr), .x_wdata(x_wdata), .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata),
    .pull_valid(pull_valid), .pull_byte(pull_byte)
  );

  function automatic logic [7:0] fill(input int i);
    return 8'(i * 37 + 11);
  endfunction

  // Memory model: combinational read, write on the clock edge.
  logic [7:0] mem [0:1023];
  assign mem_rdata = mem[mem_addr[9:0]];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= fill(i);
    end else if (mem_we) begin
      mem[mem_addr[9:0]] <= mem_wdata;
    end
  end

  // Reference model state.
  logic [7:0]  mm [0:1023];
  logic [15:0] m_sp;
  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct packed {
    logic        we, re;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic        pcw, aw, xw, cw, bw;
    logic [15:0] pcv;
    logic [7:0]  av, xv, cv, bv;
  } cyc_t;

  cyc_t eq[$];

  function automatic cyc_t blank();
    cyc_t c;
    c = '0;
    return c;
  endfunction

  task automatic pushb(input logic [7:0] d);
    cyc_t c;
    c = blank(); c.we = 1'b1; c.addr = m_sp; c.wd = d;
    mm[m_sp[9:0]] = d;
    m_sp = m_sp - 16'd1;
    eq.push_back(c);
  endtask

  task automatic pullb(output logic [7:0] d);
    cyc_t c;
    m_sp = m_sp + 16'd1;
    c = blank(); c.re = 1'b1; c.addr = m_sp;
    d = mm[m_sp[9:0]];
    eq.push_back(c);
  endtask

  task automatic check(input bit ok, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic chk_cycle(input cyc_t e, input string tag, input int i);
    bit ok;
    ok = (busy === 1'b1) && (mem_we === e.we) && (mem_re === e.re)
      && ((!e.we && !e.re) || mem_addr === e.addr)
      && (!e.we || mem_wdata === e.wd)
      && (pc_wr === e.pcw) && (!e.pcw || pc_wdata === e.pcv)
      && (a_wr === e.aw) && (!e.aw || a_wdata === e.av)
      && (x_wr === e.xw) && (!e.xw || x_wdata === e.xv)
      && (ccr_wr === e.cw) && (!e.cw || ccr_wdata === e.cv)
      && (pull_valid === e.bw) && (!e.bw || pull_byte === e.bv);
    check(ok, $sformatf("%s cyc%0d act busy=%b we=%b re=%b a=%h wd=%h pc=%b/%h a=%b/%h x=%b/%h c=%b/%h p=%b/%h exp we=%b re=%b a=%h wd=%h pc=%b/%h a=%b/%h x=%b/%h c=%b/%h p=%b/%h",
      tag, i, busy, mem_we, mem_re, mem_addr, mem_wdata, pc_wr, pc_wdata, a_wr, a_wdata,
      x_wr, x_wdata, ccr_wr, ccr_wdata, pull_valid, pull_byte,
      e.we, e.re, e.addr, e.wd, e.pcw, e.pcv, e.aw, e.av, e.xw, e.xv, e.cw, e.cv, e.bw, e.bv));
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [15:0] pc, input logic [7:0] a,
                        input logic [7:0] x, input logic [7:0] ccr, input logic [15:0] tgt,
                        input logic [15:0] vec, input logic [7:0] byt, input string tag,
                        input bit chain, input logic [2:0] chain_op);
    cyc_t c;
    logic [7:0] d0, d1, d2, d3, d4;
    logic [15:0] v1;
    eq.delete();
    v1 = vec + 16'd1;
    case (op)
      3'd0: begin
        eq.push_back(blank());
        pushb(pc[7:0]); pushb(pc[15:8]); pushb(x); pushb(a); pushb(ccr);
        c = blank(); c.re = 1'b1; c.addr = vec; eq.push_back(c);
        c.addr = v1; eq.push_back(c);
        c = blank(); c.pcw = 1'b1; c.pcv = {mm[vec[9:0]], mm[v1[9:0]]};
        c.cw = 1'b1; c.cv = ccr | 8'h08; eq.push_back(c);
      end
      3'd1: begin
        eq.push_back(blank());
        pullb(d0); pullb(d1); pullb(d2); pullb(d3); pullb(d4);
        c = blank(); c.cw = 1'b1; c.cv = d0; c.aw = 1'b1; c.av = d1;
        c.xw = 1'b1; c.xv = d2; c.pcw = 1'b1; c.pcv = {d3, d4}; eq.push_back(c);
      end
      3'd2: begin
        eq.push_back(blank());
        pushb(pc[7:0]); pushb(pc[15:8]);
        c = blank(); c.pcw = 1'b1; c.pcv = tgt; eq.push_back(c);
      end
      3'd3: begin
        eq.push_back(blank());
        pullb(d0); pullb(d1);
        c = blank(); c.pcw = 1'b1; c.pcv = {d0, d1}; eq.push_back(c);
      end
      3'd4: begin
        eq.push_back(blank());
        pushb(byt);
      end
      3'd5: begin
        eq.push_back(blank());
        pullb(d0);
        eq[eq.size()-1].bw = 1'b1;
        eq[eq.size()-1].bv = d0;
      end
      3'd6: begin
        eq.push_back(blank());
        m_sp[7:0] = 8'hFF;
      end
      default: eq.push_back(blank());
    endcase
    cmd_op = op; ctx_pc = pc; ctx_a = a; ctx_x = x; ctx_ccr = ccr;
    call_target = tgt; vec_addr = vec; push_byte = byt; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    // R9: operands change right after acceptance; the sequence must ignore it.
    cmd_valid = 1'b0;
    ctx_pc = ~pc; ctx_a = ~a; ctx_x = ~x; ctx_ccr = ~ccr;
    call_target = ~tgt; vec_addr = 16'h0200; push_byte = ~byt;
    for (int i = 0; i < eq.size(); i++) begin
      chk_cycle(eq[i], tag, i);
      if (i == eq.size() - 1 && chain) begin
        cmd_valid = 1'b1;
        cmd_op = chain_op;
        check(cmd_ready === 1'b0, $sformatf("R9 ready during last busy cycle act=%b exp=0", cmd_ready));
      end
      if (i < eq.size() - 1) @(negedge clk);
    end
    @(negedge clk);
    check(busy === 1'b0 && sp_out === m_sp,
          $sformatf("%s end act busy=%b sp=%h exp busy=0 sp=%h", tag, busy, sp_out, m_sp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd7;
    ctx_pc = '0; ctx_a = '0; ctx_x = '0; ctx_ccr = '0;
    call_target = '0; vec_addr = '0; push_byte = '0;
    for (int i = 0; i < 1024; i++) mm[i] = fill(i);
    m_sp = 16'h00FF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(sp_out === 16'h00FF && busy === 1'b0 && cmd_ready === 1'b1 && mem_we === 1'b0
          && mem_re === 1'b0 && pc_wr === 1'b0 && ccr_wr === 1'b0 && pull_valid === 1'b0,
          $sformatf("R1 reset act sp=%h busy=%b rdy=%b exp sp=00ff busy=0 rdy=1", sp_out, busy, cmd_ready));
    // R2 R3: interrupt entry, then R4 return restores every CCR bit.
    do_cmd(3'd0, 16'h1234, 8'h56, 8'h78, 8'hE5, 16'h0, 16'h03FE, 8'h0, "R2_R3 irq", 1'b0, 3'd0);
    do_cmd(3'd1, 16'h0, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0, 8'h0, "R4 rti", 1'b0, 3'd0);
    // R5 R6: call then return.
    do_cmd(3'd2, 16'hABCD, 8'h0, 8'h0, 8'h0, 16'h4000, 16'h0, 8'h0, "R5 call", 1'b0, 3'd0);
    do_cmd(3'd3, 16'h0, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0, 8'h0, "R6 ret", 1'b0, 3'd0);
    // R7 R9: push, with a pull raised during its final cycle.
    do_cmd(3'd4, 16'h0, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0, 8'h5A, "R7 push", 1'b1, 3'd5);
    do_cmd(3'd5, 16'h0, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0, 8'h0, "R7 pull", 1'b0, 3'd0);
    // R10: reserved opcode.
    do_cmd(3'd7, 16'h0, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0, 8'h0, "R10 nop", 1'b0, 3'd0);
    // R7: pull across the page, then R8 keeps the high byte.
    do_cmd(3'd5, 16'h0, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0, 8'h0, "R7 pull page", 1'b0, 3'd0);
    do_cmd(3'd6, 16'h0, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0, 8'h0, "R8 rsp", 1'b0, 3'd0);
    // R2 R3 R4 on the upper page, mask already set.
    do_cmd(3'd0, 16'hFEDC, 8'h01, 8'h80, 8'h08, 16'h0, 16'h0310, 8'h0, "R2_R3 irq2", 1'b0, 3'd0);
    do_cmd(3'd1, 16'h0, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0, 8'h0, "R4 rti2", 1'b0, 3'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule